// File: doc/BRIEF.md
# Video Memory Wait-State Generator

This block decides how long a processor stalls when it touches a character-based video memory whose timing runs on a faster pixel clock. Everything is clocked by the pixel-rate hdot clock. Inside the block, one counter divides that clock by three to mark processor cycles, and a second counter divides it by sixteen to mark wide-character boundaries. The processor-cycle marker is also driven out as an enable, so the surrounding processor model can step in lock with it.

When a video access is requested on a processor-cycle edge, READY drops. The stall first covers one narrow character time (8 hdots). It then extends to the next wide-character boundary (16 hdots). After that it runs to the first processor-cycle edge that lies strictly after that boundary, and READY rises on that edge. Because the two dividers run at unrelated ratios, the stall length depends only on where the access falls within the 48-hdot pattern they form together. It never depends on raster position. A counter reports the stall length in processor cycles and holds that value until the next access is accepted.

Top module: `vid_wait_gen`

## Requirements
- R1: While rst_n is low, both dividers are at zero, ready is 1 and wait_cnt is 0. A reset in the middle of an access abandons that access.
- R2: cpu_en is 1 in hdot 0 after reset release and then in every third hdot (pattern 1,0,0 repeating).
- R3: A request is taken only in an hdot where both cpu_en and ready are 1. A request in any other hdot leaves ready and wait_cnt unchanged.
- R4: After a request is taken in hdot t0, ready is 0 from hdot t0+1 through hdot t3-1 and is 1 again in hdot t3.
- R5: t1 = t0+8. t2 is the first hdot at or after t1 that is a multiple of 16. t3 is the first hdot strictly after t2 that is a multiple of 3. The stall (t3-t0)/3 always lies between 3 and 8 processor cycles.
- R6: ready rises only in an hdot where cpu_en is 1.
- R7: In hdot t3, wait_cnt equals (t3-t0)/3, and it keeps that value while no new request is taken.
- R8: Let phase k = (t0/3) mod 16. Phases 0..15 give stalls 6,5,4,8,7,6,5,4,3,8,7,6,5,4,8,7. Over all sixteen phases this makes one stall of 3, three stalls each of 4 to 8, and a total of 93 cycles.
- R9: Two accesses with the same phase k get the same stall, whatever the absolute hdot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hdot | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Video memory access request |
| ready | output | 1 | Processor may proceed; 0 while stalled |
| cpu_en | output | 1 | Processor-cycle edge marker, one hdot in three |
| wait_cnt | output | WAIT_W | Stall length of the last access, in processor cycles |

## Verification
The main test issues one access at each of the sixteen processor-cycle positions within the 48-hdot pattern. Each position gives a different arrangement of the 8-hdot step, the 16-hdot alignment and the 3-hdot alignment, so a wrong boundary rule shows up as a shifted stall in particular phases and as a wrong histogram or total. The same phases are then repeated two full patterns later, which separates true phase dependence from any dependence on absolute time. Directed cases cover:
- requests placed off the processor edge;
- a request held for the whole stall;
- a reset in the middle of an access;
- the phase where the 8-hdot step lands exactly on a wide boundary, which is the only phase that yields three cycles.

// File: rtl/vwg_pkg.sv
package vwg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HCHAR  = 2'd1,
        ST_LALIGN = 2'd2,
        ST_CALIGN = 2'd3
    } vwg_state_e;

endpackage

// File: rtl/vwg_phase.sv
module vwg_phase #(
    parameter int CPU_DIV     = 3,
    parameter int LCHAR_HDOTS = 16
) (
    input  logic clk_hdot,
    input  logic rst_n,
    output logic cpu_start,
    output logic cpu_last,
    output logic lchar_edge
);

    localparam int PH3_W = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1;
    localparam int PHL_W = (LCHAR_HDOTS > 1) ? $clog2(LCHAR_HDOTS) : 1;

    typedef struct packed {
        logic [PH3_W-1:0] ph3;
        logic [PHL_W-1:0] phl;
    } phase_t;

    phase_t phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (phase_q.ph3 == PH3_W'(CPU_DIV - 1)) begin
            phase_d.ph3 = '0;
        end else begin
            phase_d.ph3 = phase_q.ph3 + 1'b1;
        end
        if (phase_q.phl == PHL_W'(LCHAR_HDOTS - 1)) begin
            phase_d.phl = '0;
        end else begin
            phase_d.phl = phase_q.phl + 1'b1;
        end
    end

    always_ff @(posedge clk_hdot or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign cpu_start  = (phase_q.ph3 == '0);
    assign cpu_last   = (phase_q.ph3 == PH3_W'(CPU_DIV - 1));
    assign lchar_edge = (phase_q.phl == '0);

endmodule

// File: rtl/vwg_seq.sv
module vwg_seq
    import vwg_pkg::*;
#(
    parameter int HCHAR_HDOTS = 8,
    parameter int WAIT_W      = 4
) (
    input  logic              clk_hdot,
    input  logic              rst_n,
    input  logic              req,
    input  logic              cpu_start,
    input  logic              cpu_last,
    input  logic              lchar_edge,
    output logic              ready,
    output logic [WAIT_W-1:0] wait_cnt
);

    localparam int HCNT_W = $clog2(HCHAR_HDOTS + 1);

    typedef struct packed {
        vwg_state_e        st;
        logic [HCNT_W-1:0] hcnt;
        logic [WAIT_W-1:0] wcnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (cpu_start && req) begin
                    seq_d.st   = ST_HCHAR;
                    seq_d.hcnt = HCNT_W'(1);
                    seq_d.wcnt = WAIT_W'(1);
                end
            end
            ST_HCHAR: begin
                if (seq_q.hcnt == HCNT_W'(HCHAR_HDOTS)) begin
                    if (lchar_edge) begin
                        seq_d.st = cpu_last ? ST_IDLE : ST_CALIGN;
                    end else begin
                        seq_d.st = ST_LALIGN;
                    end
                end else begin
                    seq_d.hcnt = seq_q.hcnt + 1'b1;
                end
            end
            ST_LALIGN: begin
                if (lchar_edge) begin
                    seq_d.st = cpu_last ? ST_IDLE : ST_CALIGN;
                end
            end
            ST_CALIGN: begin
                if (cpu_last) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (seq_q.st != ST_IDLE && cpu_start) begin
            seq_d.wcnt = seq_q.wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk_hdot or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, hcnt: '0, wcnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready    = (seq_q.st == ST_IDLE);
    assign wait_cnt = seq_q.wcnt;

endmodule

// File: rtl/vid_wait_gen.sv
module vid_wait_gen #(
    parameter int CPU_DIV     = 3,
    parameter int HCHAR_HDOTS = 8,
    parameter int LCHAR_HDOTS = 16,
    parameter int WAIT_W      = 4
) (
    input  logic              clk_hdot,
    input  logic              rst_n,
    input  logic              req,
    output logic              ready,
    output logic              cpu_en,
    output logic [WAIT_W-1:0] wait_cnt
);

    logic cpu_start;
    logic cpu_last;
    logic lchar_edge;

    vwg_phase #(
        .CPU_DIV     (CPU_DIV),
        .LCHAR_HDOTS (LCHAR_HDOTS)
    ) u_phase (
        .clk_hdot   (clk_hdot),
        .rst_n      (rst_n),
        .cpu_start  (cpu_start),
        .cpu_last   (cpu_last),
        .lchar_edge (lchar_edge)
    );

    vwg_seq #(
        .HCHAR_HDOTS (HCHAR_HDOTS),
        .WAIT_W      (WAIT_W)
    ) u_seq (
        .clk_hdot   (clk_hdot),
        .rst_n      (rst_n),
        .req        (req),
        .cpu_start  (cpu_start),
        .cpu_last   (cpu_last),
        .lchar_edge (lchar_edge),
        .ready      (ready),
        .wait_cnt   (wait_cnt)
    );

    assign cpu_en = cpu_start;

endmodule

// File: rtl/vid_wait_gen_chk.sv
module vid_wait_gen_chk #(
    parameter int WAIT_W   = 4,
    parameter int MIN_WAIT = 3,
    parameter int MAX_WAIT = 8,
    parameter int CPU_DIV  = 3
) (
    input logic              clk_hdot,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              cpu_en,
    input logic [WAIT_W-1:0] wait_cnt
);

    localparam int MAX_LOW = MAX_WAIT * CPU_DIV - 2;
    localparam int LEN_W   = $clog2(MAX_WAIT * CPU_DIV + 2);

    logic [LEN_W-1:0] low_len_q;

    always_ff @(posedge clk_hdot or negedge rst_n) begin
        if (!rst_n) begin
            low_len_q <= '0;
        end else if (ready) begin
            low_len_q <= '0;
        end else if (low_len_q != '1) begin
            low_len_q <= low_len_q + 1'b1;
        end
    end

    AST_CPU_EN_SPACING: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        cpu_en |=> !cpu_en); // R2

    AST_IGNORE_OFF_EDGE: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        (ready && !cpu_en) |=> ready); // R3

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        (ready && cpu_en && req) |=> !ready); // R4

    AST_STALL_BOUND: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        !ready |-> (low_len_q <= LEN_W'(MAX_LOW))); // R5

    AST_WAIT_RANGE: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        $rose(ready) |-> (wait_cnt >= WAIT_W'(MIN_WAIT) && wait_cnt <= WAIT_W'(MAX_WAIT))); // R5

    AST_READY_RISE_ALIGNED: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        $rose(ready) |-> cpu_en); // R6

    AST_HOLD_COUNT: assert property (@(posedge clk_hdot) disable iff (!rst_n)
        (ready && !(cpu_en && req)) |=> $stable(wait_cnt)); // R7

endmodule

bind vid_wait_gen vid_wait_gen_chk #(
    .WAIT_W  (WAIT_W),
    .CPU_DIV (CPU_DIV)
) u_chk (
    .clk_hdot (clk_hdot),
    .rst_n    (rst_n),
    .req      (req),
    .ready    (ready),
    .cpu_en   (cpu_en),
    .wait_cnt (wait_cnt)
);

// File: tb/vid_wait_gen_bench.sv
`timescale 1ns/1ps
module vid_wait_gen_bench;

    localparam int WAIT_W = 4;
    localparam int EXP_WAIT [16] = '{6, 5, 4, 8, 7, 6, 5, 4, 3, 8, 7, 6, 5, 4, 8, 7};

    logic              clk_hdot = 1'b0;
    logic              rst_n    = 1'b0;
    logic              req      = 1'b0;
    logic              ready;
    logic              cpu_en;
    logic [WAIT_W-1:0] wait_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk_hdot = ~clk_hdot;

    vid_wait_gen #(.WAIT_W(WAIT_W)) u_vid_wait_gen (
        .clk_hdot (clk_hdot),
        .rst_n    (rst_n),
        .req      (req),
        .ready    (ready),
        .cpu_en   (cpu_en),
        .wait_cnt (wait_cnt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Leaves the bench in hdot 0, sampled away from the rising edge.
    task automatic do_reset();
        req   = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk_hdot);
        rst_n = 1'b1;
    endtask

    // From hdot 0, request in hdot t0 (held if hold=1), return t3 and outputs there.
    task automatic run_access(input int t0, input bit hold,
                              output int t3, output bit en_at, output int cnt_at);
        int t;
        if (t0 > 0) repeat (t0) @(negedge clk_hdot);
        req = 1'b1;
        @(negedge clk_hdot);
        if (!hold) req = 1'b0;
        t = t0 + 1;
        while (!ready && t < t0 + 60) begin
            @(negedge clk_hdot);
            t++;
        end
        req    = 1'b0;
        t3     = t;
        en_at  = cpu_en;
        cnt_at = int'(wait_cnt);
    endtask

    initial begin
        int hist [9];
        int total;
        int t3;
        bit en_at;
        int cnt_at;

        for (int i = 0; i < 9; i++) hist[i] = 0;
        total = 0;

        // R1: reset state
        rst_n = 1'b0;
        #12;
        check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        check(wait_cnt == '0, "R1 wait_cnt in reset", int'(wait_cnt), 0);

        // R2: processor edge pattern
        do_reset();
        for (int h = 0; h < 9; h++) begin
            check(cpu_en == ((h % 3) == 0), "R2 cpu_en pattern", int'(cpu_en), int'((h % 3) == 0));
            @(negedge clk_hdot);
        end

        // R4 R5 R7 R8: sweep of all sixteen phases from the table
        for (int k = 0; k < 16; k++) begin
            int w;
            do_reset();
            run_access(3 * k, 1'b0, t3, en_at, cnt_at);
            w = (t3 - 3 * k) / 3;
            check(((t3 - 3 * k) % 3) == 0 && w == EXP_WAIT[k], "R4/R5 stall for phase", w, EXP_WAIT[k]);
            check(en_at == 1'b1, "R6 cpu_en at ready rise", int'(en_at), 1);
            check(cnt_at == EXP_WAIT[k], "R7 wait_cnt at ready rise", cnt_at, EXP_WAIT[k]);
            if (w >= 0 && w < 9) hist[w]++;
            total += w;
        end
        check(total == 93, "R8 total over phases", total, 93);
        check(hist[3] == 1, "R8 count of stall 3", hist[3], 1);
        for (int w = 4; w <= 8; w++)
            check(hist[w] == 3, "R8 count of stall", hist[w], 3);

        // R9: same phases two full patterns later
        for (int k = 0; k < 16; k += 3) begin
            do_reset();
            run_access(3 * k + 96, 1'b0, t3, en_at, cnt_at);
            check((t3 - 3 * k - 96) == 3 * EXP_WAIT[k], "R9 stall later in time", (t3 - 3 * k - 96) / 3, EXP_WAIT[k]);
        end

        // R7: count held while idle
        do_reset();
        run_access(24, 1'b0, t3, en_at, cnt_at);
        repeat (10) @(negedge clk_hdot);
        check(wait_cnt == 4'd3, "R7 wait_cnt held", int'(wait_cnt), 3);
        check(ready == 1'b1, "R7 ready stays high", int'(ready), 1);

        // R3: requests in hdots 1 and 2 (cpu_en low) have no effect
        do_reset();
        @(negedge clk_hdot);
        req = 1'b1;
        @(negedge clk_hdot);
        @(negedge clk_hdot);
        req = 1'b0;
        for (int h = 0; h < 6; h++) begin
            check(ready == 1'b1, "R3 off-edge request ignored", int'(ready), 1);
            @(negedge clk_hdot);
        end
        check(wait_cnt == '0, "R3 wait_cnt untouched", int'(wait_cnt), 0);

        // R3: request held through the stall does not restart it
        do_reset();
        run_access(0, 1'b1, t3, en_at, cnt_at);
        check(t3 == 18, "R3 held request, stall unchanged", t3 / 3, 6);
        check(cnt_at == 6, "R3 held request, wait_cnt", cnt_at, 6);

        // R1: reset in mid-access abandons it
        do_reset();
        req = 1'b1;
        @(negedge clk_hdot);
        req = 1'b0;
        repeat (4) @(negedge clk_hdot);
        check(ready == 1'b0, "R4 stalled before reset", int'(ready), 0);
        rst_n = 1'b0;
        #1;
        check(ready == 1'b1, "R1 reset cancels access", int'(ready), 1);
        check(wait_cnt == '0, "R1 reset clears wait_cnt", int'(wait_cnt), 0);
        @(negedge clk_hdot);
        rst_n = 1'b1;
        repeat (4) @(negedge clk_hdot);
        check(ready == 1'b1, "R1 idle after reset", int'(ready), 1);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule